// File: doc/BRIEF.md
# Register-Mapped Multiply/Divide Unit

This block is a small arithmetic peripheral that sits behind a simple word-wide register port. Software loads operands into three pairs of data registers, A, B and C, then writes a control register to choose an operation and start it. Two operations exist. The first is an unsigned multiply of two 16-bit words. The second is an unsigned 32-by-32 divide that produces one quotient bit per clock.

The operand registers also hold the results. A multiply takes the low word of pair A times the high word of pair A and leaves the 32-bit product in pair B. A divide takes {AH, AL} as the dividend and {BH, BL} as the divisor. It writes the quotient back over pair A and the remainder into the read-only pair C. A multiply leaves pair C alone. While the divider runs, the operand registers and the control register are locked against writes. Each finished operation raises a one-cycle `done` pulse.

Top module: `muldiv_regs`

## Requirements
- R1: After reset, every register address (0 to 6) reads 0000h and `done` is low.
- R2: Register addresses are 0=AL, 1=AH, 2=BL, 3=BH, 4=CL, 5=CH, 6=control, and 7 reads 0000h. `rdata` is registered: the word at `addr` on a rising edge appears after that edge. Writes to AL, AH, BL and BH read back unchanged.
- R3: CL and CH are read-only. A write to address 4 or 5 changes nothing.
- R4: Writing the control register with bit 7 = 0 and bit 0 = 1 starts a multiply, giving {BH, BL} = AL × AH with pair A unchanged. `done` goes high right after the 2nd rising edge, counting the write edge as the 1st. After that, bit 0 of the control register reads 0.
- R5: A multiply leaves {CH, CL} at its previous value.
- R6: Writing the control register with bit 7 = 1 and bit 0 = 1 starts a divide. On completion, {AH, AL} holds the quotient, {CH, CL} holds the remainder, and pair B is unchanged.
- R7: While a divide runs, the control register reads 0081h. `done` goes high right after the 34th rising edge, counting the write edge as the 1st. It stays high for exactly one cycle, after which the control register reads 0080h.
- R8: Dividing by zero gives a quotient of FFFFFFFFh and a remainder equal to the dividend.
- R9: While an operation is busy, writes to AL, AH, BL, BH and the control register are ignored.
- R10: Control bit 7 holds the mode and reads back as written. A control write with bit 0 = 0 sets the mode without starting anything.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address for read and write |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | W (16) | Write data word |
| rdata | output | W (16) | Registered read data for `addr` |
| done | output | 1 | One-cycle pulse when an operation finishes |

## Verification
Some behaviours are checked on every cycle by the assertions. A multiply always clears busy on the next edge. Pair C only changes on the cycle the divider finishes. Pair B holds while a divide is locked. A busy divide always matches an active divider. The finish pulse never lasts two cycles. At finish with a nonzero divisor, the remainder is below the divisor. Other behaviours only show up in the bench's scenarios. These are the arithmetic results over swept corner and random operands, the exact completion latencies, the divide-by-zero convention, and the ignored writes, whose effect is observed by reading the registers back afterwards.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    ADR_AL   = 3'd0,
    ADR_AH   = 3'd1,
    ADR_BL   = 3'd2,
    ADR_BH   = 3'd3,
    ADR_CL   = 3'd4,
    ADR_CH   = 3'd5,
    ADR_CTRL = 3'd6
  } reg_addr_e;

  localparam int MODE_BIT = 7;
  localparam int GO_BIT   = 0;
endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod_q;

  always_ff @(posedge clk) begin
    prod_q <= PW'(a) * PW'(b);
  end

  assign prod = prod_q;
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          busy,
  output logic          fin,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem
);
  localparam int CW = $clog2(DW);

  logic [DW:0]   r_q;
  logic [DW-1:0] q_q, d_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, fin_q;
  logic [DW:0]   r_sh;
  logic          ge;

  always_comb begin
    r_sh = {r_q[DW-1:0], q_q[DW-1]};
    ge   = (r_sh >= {1'b0, d_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_q    <= '0;
      q_q    <= '0;
      d_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (start && !busy_q) begin
        r_q    <= '0;
        q_q    <= dividend;
        d_q    <= divisor;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        r_q   <= ge ? (r_sh - {1'b0, d_q}) : r_sh;
        q_q   <= {q_q[DW-2:0], ge};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(DW - 1)) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign fin  = fin_q;
  assign quo  = q_q;
  assign rem  = r_q[DW-1:0];

  // R7: the finish strobe lasts exactly one cycle
  assert_fin_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    fin_q |=> !fin_q);

  // R6: at finish, a nonzero divisor leaves a remainder below it
  assert_rem_below_R6: assert property (@(posedge clk) disable iff (rst)
    (fin_q && d_q != '0) |-> (r_q[DW-1:0] < d_q));

  // R7: a start on an idle divider makes it busy next cycle
  assert_start_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_q) |=> busy_q);
endmodule

// File: rtl/muldiv_regs.sv
module muldiv_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   addr,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         done
);
  import muldiv_pkg::*;

  localparam int DW = 2 * W;

  logic [W-1:0]  al_q, ah_q, bl_q, bh_q, cl_q, ch_q;
  logic          mode_q, busy_q, done_q;
  logic [W-1:0]  rdata_q;
  logic [DW-1:0] prod, quo, rem;
  logic          div_busy, div_fin;
  logic          ctrl_wr, go;

  assign ctrl_wr = wr_en && (addr == ADR_CTRL) && !busy_q;
  assign go      = ctrl_wr && wdata[GO_BIT];

  muldiv_mul #(.W(W)) u_mul (
    .clk  (clk),
    .a    (al_q),
    .b    (ah_q),
    .prod (prod)
  );

  muldiv_div #(.DW(DW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (go && wdata[MODE_BIT]),
    .dividend ({ah_q, al_q}),
    .divisor  ({bh_q, bl_q}),
    .busy     (div_busy),
    .fin      (div_fin),
    .quo      (quo),
    .rem      (rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      al_q   <= '0;
      ah_q   <= '0;
      bl_q   <= '0;
      bh_q   <= '0;
      cl_q   <= '0;
      ch_q   <= '0;
      mode_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ctrl_wr) begin
        mode_q <= wdata[MODE_BIT];
        if (wdata[GO_BIT]) busy_q <= 1'b1;
      end
      if (wr_en && !busy_q) begin
        case (addr)
          ADR_AL:  al_q <= wdata;
          ADR_AH:  ah_q <= wdata;
          ADR_BL:  bl_q <= wdata;
          ADR_BH:  bh_q <= wdata;
          default: ;
        endcase
      end
      if (busy_q && !mode_q) begin
        {bh_q, bl_q} <= prod;
        busy_q       <= 1'b0;
        done_q       <= 1'b1;
      end
      if (busy_q && mode_q && div_fin) begin
        {ah_q, al_q} <= quo;
        {ch_q, cl_q} <= rem;
        busy_q       <= 1'b0;
        done_q       <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (addr)
        ADR_AL:   rdata_q <= al_q;
        ADR_AH:   rdata_q <= ah_q;
        ADR_BL:   rdata_q <= bl_q;
        ADR_BH:   rdata_q <= bh_q;
        ADR_CL:   rdata_q <= cl_q;
        ADR_CH:   rdata_q <= ch_q;
        ADR_CTRL: begin
          rdata_q           <= '0;
          rdata_q[MODE_BIT] <= mode_q;
          rdata_q[GO_BIT]   <= busy_q;
        end
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;
  assign done  = done_q;

  // R4: a multiply finishes on the edge after it starts
  assert_mul_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !mode_q) |=> !busy_q);

  // R5: the remainder pair moves only when the divider finishes
  assert_c_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !div_fin |=> $stable({ch_q, cl_q}));

  // R9: divisor pair cannot be written during a divide
  assert_b_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && mode_q && wr_en && (addr == ADR_BL || addr == ADR_BH))
      |=> $stable({bh_q, bl_q}));

  // R7: a busy divide is always backed by an active or finishing divider
  assert_div_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && mode_q) |-> (div_busy || div_fin));
endmodule

// File: tb/tb_muldiv_regs.sv
module tb_muldiv_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = 3'd0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        done;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;
  logic [31:0] c_model = 32'd0;

  always #4 clk = ~clk;

  muldiv_regs #(.W(16)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic rd32(input logic [2:0] lo, output logic [31:0] v);
    logic [15:0] l, h;
    rd(lo, l);
    rd(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic run(input logic [15:0] c, output int n);
    wr(3'd6, c);
    n = 1;
    forever begin
      @(negedge clk);
      if (done || n > 100) break;
      @(posedge clk);
      n++;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R7 done one cycle", {31'd0, done}, 32'd0);
  endtask

  function automatic logic [15:0] pick16(int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return 16'h8000;
      4: return 16'h7FFF;
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic logic [31:0] pick32(int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h0001_0000;
      5: return 32'h0000_FFFF;
      6: return $urandom >> ($urandom % 32);
      default: return $urandom;
    endcase
  endfunction

  task automatic do_mul(input logic [15:0] x, input logic [15:0] y);
    logic [31:0] v;
    int n;
    wr(3'd0, x);
    wr(3'd1, y);
    run(16'h0001, n);
    chk("R4 mul latency", n, 2);
    rd32(3'd2, v);
    chk("R4 product", v, 32'(x) * 32'(y));
    rd32(3'd0, v);
    chk("R4 A kept", v, {y, x});
    rd32(3'd4, v);
    chk("R5 C kept on mul", v, c_model);
  endtask

  task automatic do_div(input logic [31:0] dd, input logic [31:0] dv);
    logic [31:0] v, eq, er;
    int n;
    wr(3'd0, dd[15:0]); wr(3'd1, dd[31:16]);
    wr(3'd2, dv[15:0]); wr(3'd3, dv[31:16]);
    run(16'h0081, n);
    chk("R7 div latency", n, 34);
    if (dv == 0) begin eq = 32'hFFFF_FFFF; er = dd; end
    else begin eq = dd / dv; er = dd % dv; end
    rd32(3'd0, v);
    chk(dv == 0 ? "R8 quotient" : "R6 quotient", v, eq);
    rd32(3'd4, v);
    chk(dv == 0 ? "R8 remainder" : "R6 remainder", v, er);
    c_model = er;
    rd32(3'd2, v);
    chk("R6 B kept", v, dv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [31:0] v;
    int n;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 reset read", {16'd0, d}, 32'd0);
    end
    chk("R1 done low", {31'd0, done}, 32'd0);

    // R2 data register write/read-back
    wr(3'd0, 16'h1234); wr(3'd1, 16'hABCD); wr(3'd2, 16'h5A5A); wr(3'd3, 16'hC3C3);
    rd32(3'd0, v); chk("R2 A readback", v, 32'hABCD_1234);
    rd32(3'd2, v); chk("R2 B readback", v, 32'hC3C3_5A5A);
    rd(3'd7, d); chk("R2 addr7 zero", {16'd0, d}, 32'd0);

    // R3 C read-only
    wr(3'd4, 16'hDEAD); wr(3'd5, 16'hBEEF);
    rd32(3'd4, v); chk("R3 C read-only", v, c_model);

    // R10 mode bit without start
    wr(3'd6, 16'h0080);
    rd(3'd6, d); chk("R10 mode set", {16'd0, d}, 32'h80);
    @(negedge clk); chk("R10 no start", {31'd0, done}, 32'd0);
    wr(3'd6, 16'h0000);
    rd(3'd6, d); chk("R10 mode clear", {16'd0, d}, 32'h0);

    // R4/R5 multiply sweep
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        do_mul(pick16(i), pick16(j));
    rd(3'd6, d); chk("R4 busy clear", {16'd0, d}, 32'h0);

    // R6/R8 divide sweep
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++)
        do_div(pick32(i), pick32(j));

    // R5 after a divide set C, a multiply keeps it
    do_mul(16'h00FF, 16'h0101);

    // R7/R9 busy read and locked writes
    wr(3'd0, 16'h0007); wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0002); wr(3'd3, 16'h0000);
    wr(3'd6, 16'h0081);
    rd(3'd6, d); chk("R7 busy reads 81h", {16'd0, d}, 32'h81);
    wr(3'd0, 16'h1111); wr(3'd3, 16'h2222); wr(3'd6, 16'h0001);
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    rd32(3'd0, v); chk("R9 A locked, quotient", v, 32'd3);
    rd32(3'd2, v); chk("R9 B locked", v, 32'd2);
    rd32(3'd4, v); chk("R9 remainder", v, 32'd1);
    rd(3'd6, d); chk("R7 R9 ctrl after divide", {16'd0, d}, 32'h80);

    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule